// File: doc/BRIEF.md
# Manchester Receive Clock Recovery

This block takes a raw Manchester-coded serial line and recovers both its bit timing and its data. It runs on a local oversampling clock at a fixed, agreed multiple of the bit rate (`OVERSAMPLE` clocks per bit, 16 by default). Each bit carries a transition at its midpoint. The receiver treats that mid-bit transition as its timing reference, so it needs no separate clock wire.

The line is first passed through a synchronizer. A change between consecutive synchronized samples counts as an edge. From each accepted reference edge, a phase counter runs for three quarters of a bit and captures the line level, which is the first-half level of the following bit. The counter then waits for that bit's own midpoint edge in a narrow window. If the edge arrives, the captured bit is confirmed and presented to the consumer, and the counter restarts from the new edge. This cancels accumulated phase error.

If the edge does not arrive, the reference was a boundary between two equal bits rather than a midpoint. In that case the receiver:
- drops the captured bit,
- clears its lock indication, and
- slides its reference half a bit forward.

Transmitters therefore send a run of throwaway preamble bits before real data. Alternating ones and zeros give the fastest alignment.

Top module: `mrx_clock_recovery`

## Requirements
- R1: A bit sent as high-then-low is delivered as 1, and one sent as low-then-high as 0. Confirmed bits leave on `bitData` in the order sent.
- R2: Each confirmed bit is marked by a `bitValid` pulse exactly one clock wide. The data is the line level captured three quarters of a bit (12 clocks at the default ratio) after the reference edge.
- R3: A mid-bit edge is accepted when it falls within `OVERSAMPLE` ± `EDGE_TOL` clocks of the previous reference. Bit periods of 15 and 17 clocks therefore decode without error at the defaults. The phase counter never runs past the end of that window.
- R4: Edges that fall outside the acceptance window are ignored. This includes the boundary transitions between equal adjacent bits, so runs of all ones or all zeros decode correctly.
- R5: When no edge falls inside the window, the pending bit is discarded without a `bitValid` pulse, `locked` falls, and the reference moves half a bit forward. A lead-in whose first edge is a bit boundary still yields exactly one output per transmitted bit after the first, with no spurious output.
- R6: `locked` rises on the same cycle as the `LOCK_BITS`-th (default 8) consecutive confirmed bit, and not on the one before it. It stays high until an edge is missed.
- R7: While `rstN` is low, `bitValid`, `bitData` and `locked` are all 0 regardless of line activity.
- R8: A line with no transitions produces no `bitValid` pulses and leaves `locked` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, `OVERSAMPLE` cycles per bit |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Raw Manchester serial line, asynchronous to `clk` |
| bitData | output | 1 | Recovered bit value, meaningful when `bitValid` is high |
| bitValid | output | 1 | One-cycle strobe marking a confirmed bit |
| locked | output | 1 | High after `LOCK_BITS` consecutive confirmed bits |

## Verification
The bench decodes lead-ins that start on a midpoint edge and lead-ins that start on a bit boundary. A receiver that skipped the half-bit slip, or emitted the bit it should have discarded, would produce one bit too many or a shifted stream. Payloads of all ones and all zeros put transitions halfway between references: a receiver that accepted edges outside the window would restart there and sample the wrong halves. Bit periods one clock short and one clock long test the window edges, and an off-by-one window would lose lock. A deliberately corrupted bit mid-stream and the cycle on which lock first rises expose a lock counter that fails to clear or that fires one bit early or late.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  // Tracking state of the receiver
  typedef enum logic {
    ST_HUNT  = 1'b0,  // waiting for any first edge
    ST_TRACK = 1'b1   // phase counter running from a reference edge
  } mrxState_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic restart;  // load phase counter with 1 (edge taken as new reference)
    logic slip;     // move reference half a bit forward
    logic advance;  // increment phase counter
    logic capture;  // store synchronized line level as pending bit
    logic emit;     // present pending bit with a valid pulse
  } mrxStrobe_t;

endpackage

// File: rtl/mrx_line_sync.sv
module mrx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/mrx_datapath.sv
module mrx_datapath
  import mrx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int EDGE_TOL    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           lineIn,
  input  mrxStrobe_t     strobe,
  output logic           edgeDet,
  output logic [CW-1:0]  phaseCnt,
  output logic           bitData,
  output logic           bitValid
);

  // Counter value one cycle after a missed window, measured from a
  // reference half a bit later than the abandoned one.
  localparam int SLIP_DIST = OVERSAMPLE + EDGE_TOL + 1 - OVERSAMPLE / 2;
  localparam logic [CW-1:0] SLIP_LOAD = CW'(SLIP_DIST);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic lineSync;
  logic linePrev;
  logic heldBit;

  mrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (lineIn),
    .dout (lineSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) linePrev <= 1'b0;
    else       linePrev <= lineSync;
  end

  assign edgeDet = lineSync ^ linePrev;

  // Phase counter: distance in clocks from the current reference edge
  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strobe.restart)  phaseCnt <= ONE;
    else if (strobe.slip)     phaseCnt <= SLIP_LOAD;
    else if (strobe.advance)  phaseCnt <= phaseCnt + 1'b1;
  end

  // Pending bit, held until its own mid-bit edge confirms it
  always_ff @(posedge clk) begin
    if (!rstN)               heldBit <= 1'b0;
    else if (strobe.capture) heldBit <= lineSync;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitValid <= 1'b0;
      bitData  <= 1'b0;
    end else begin
      bitValid <= strobe.emit;
      if (strobe.emit) bitData <= heldBit;
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R3
  valid_after_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(edgeDet));

endmodule

// File: rtl/mrx_control.sv
module mrx_control
  import mrx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int EDGE_TOL   = 1,
  parameter int LOCK_BITS  = 8,
  parameter int CW         = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           edgeDet,
  input  logic [CW-1:0]  phaseCnt,
  output mrxStrobe_t     strobe,
  output logic           locked
);

  localparam int GW = $clog2(LOCK_BITS + 1);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(OVERSAMPLE * 3 / 4);
  localparam logic [CW-1:0] WIN_LO    = CW'(OVERSAMPLE - EDGE_TOL);
  localparam logic [CW-1:0] WIN_HI    = CW'(OVERSAMPLE + EDGE_TOL);
  localparam logic [GW-1:0] GOOD_MAX  = GW'(LOCK_BITS);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_BITS - 1);

  mrxState_t state, nextState;
  logic [GW-1:0] goodCnt;
  logic          miss;

  always_comb begin
    strobe    = '0;
    miss      = 1'b0;
    nextState = state;
    case (state)
      ST_HUNT: begin
        if (edgeDet) begin
          strobe.restart = 1'b1;
          nextState      = ST_TRACK;
        end
      end
      ST_TRACK: begin
        strobe.advance = 1'b1;
        strobe.capture = (phaseCnt == SAMPLE_AT);
        if (edgeDet && (phaseCnt >= WIN_LO)) begin
          strobe.restart = 1'b1;
          strobe.emit    = 1'b1;
        end else if (phaseCnt == WIN_HI) begin
          strobe.slip = 1'b1;
          miss        = 1'b1;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end

  // Consecutive confirmed-bit count and lock flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCnt <= '0;
      locked  <= 1'b0;
    end else if (miss) begin
      goodCnt <= '0;
      locked  <= 1'b0;
    end else if (strobe.emit && (goodCnt != GOOD_MAX)) begin
      goodCnt <= goodCnt + 1'b1;
      if (goodCnt == GOOD_LAST) locked <= 1'b1;
    end
  end

  // R3
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRACK) |-> (phaseCnt <= WIN_HI));

  // R5
  miss_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    miss |=> !locked);

  // R8
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT) |-> !strobe.emit);

endmodule

// File: rtl/mrx_clock_recovery.sv
module mrx_clock_recovery
  import mrx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int EDGE_TOL    = 1,
  parameter int LOCK_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic bitData,
  output logic bitValid,
  output logic locked
);

  localparam int CW = $clog2(OVERSAMPLE + EDGE_TOL + 2);

  mrxStrobe_t     strobe;
  logic           edgeDet;
  logic [CW-1:0]  phaseCnt;

  mrx_datapath #(
    .OVERSAMPLE  (OVERSAMPLE),
    .EDGE_TOL    (EDGE_TOL),
    .SYNC_STAGES (SYNC_STAGES),
    .CW          (CW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .strobe   (strobe),
    .edgeDet  (edgeDet),
    .phaseCnt (phaseCnt),
    .bitData  (bitData),
    .bitValid (bitValid)
  );

  mrx_control #(
    .OVERSAMPLE (OVERSAMPLE),
    .EDGE_TOL   (EDGE_TOL),
    .LOCK_BITS  (LOCK_BITS),
    .CW         (CW)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeDet  (edgeDet),
    .phaseCnt (phaseCnt),
    .strobe   (strobe),
    .locked   (locked)
  );

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> bitValid);

endmodule

// File: tb/mrx_clock_recovery_test.sv
module mrx_clock_recovery_test;

  typedef struct packed {
    logic [3:0]  h1;       // clocks in first half of each bit
    logic [3:0]  h2;       // clocks in second half
    logic        leadOne;  // preamble starts with a 1 (first edge is a boundary)
    logic [15:0] payload;  // sent MSB first
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'd8, 4'd8, 1'b0, 16'hA5C3},
    '{4'd8, 4'd8, 1'b1, 16'h3C96},
    '{4'd8, 4'd8, 1'b0, 16'hFFFF},
    '{4'd8, 4'd8, 1'b0, 16'h0000},
    '{4'd8, 4'd9, 1'b0, 16'h1E7B},
    '{4'd7, 4'd8, 1'b0, 16'hC3A1},
    '{4'd8, 4'd7, 1'b0, 16'h5A0F}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0;
  logic bitData, bitValid, locked;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic rxBits [64];
  logic rxLock [64];
  int   rxCount = 0;
  logic prevLock = 1'b0;
  bit   lockFell = 1'b0;

  always #4 clk = ~clk;

  mrx_clock_recovery uut (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .bitData  (bitData),
    .bitValid (bitValid),
    .locked   (locked)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (bitValid && rxCount < 64) begin
        rxBits[rxCount] = bitData;
        rxLock[rxCount] = locked;
      end
      if (bitValid) rxCount = rxCount + 1;
      if (prevLock && !locked) lockFell = 1'b1;
    end
    prevLock = locked;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineIn = 1'b0;
    repeat (4) @(negedge clk);
    rxCount = 0;
    lockFell = 1'b0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int h1, input int h2);
    lineIn = b;
    repeat (h1) @(negedge clk);
    lineIn = ~b;
    repeat (h2) @(negedge clk);
  endtask

  task automatic sendPreamble(input logic lead, input int n, input int h1, input int h2);
    for (int i = 0; i < n; i++) sendBit(lead ^ logic'(i % 2), h1, h2);
  endtask

  task automatic runVector(input int idx, input vec_t vc);
    logic [15:0] gotPre, expPre, gotPay;
    bit lockOk;
    string tag;
    tag = (vc.leadOne) ? "R5" : ((vc.payload == 16'hFFFF || vc.payload == 16'h0000) ? "R4" :
          ((vc.h1 + vc.h2 != 16) ? "R3" : "R1"));
    doReset();
    sendPreamble(vc.leadOne, 16, int'(vc.h1), int'(vc.h2));
    for (int i = 15; i >= 0; i--) sendBit(vc.payload[i], int'(vc.h1), int'(vc.h2));
    repeat (60) @(negedge clk);
    // R2 / R5: one confirmed bit per transmitted bit after the first
    check(rxCount == 31, tag, $sformatf("vec%0d R2 valid count", idx), rxCount, 31);
    gotPre = '0; expPre = '0; gotPay = '0;
    for (int k = 0; k < 15; k++) begin
      gotPre[k] = rxBits[k];
      expPre[k] = vc.leadOne ^ logic'((k + 1) % 2);
    end
    for (int k = 0; k < 16; k++) gotPay[15 - k] = rxBits[15 + k];
    // R1: preamble stream, then payload MSB first
    check(gotPre == expPre, tag, $sformatf("vec%0d R1 preamble bits", idx), gotPre, expPre);
    check(gotPay == vc.payload, tag, $sformatf("vec%0d R1 payload", idx), gotPay, vc.payload);
    // R6: lock rises exactly with the 8th confirmed bit
    check(rxLock[6] == 1'b0, "R6", $sformatf("vec%0d lock at 7th bit", idx), rxLock[6], 0);
    lockOk = 1'b1;
    for (int k = 7; k < 31; k++) if (rxLock[k] !== 1'b1) lockOk = 1'b0;
    check(lockOk, "R6", $sformatf("vec%0d lock from 8th bit on", idx), lockOk, 1);
    // R5: missed edges after the line goes quiet drop lock
    check(locked == 1'b0, "R5", $sformatf("vec%0d lock after line stops", idx), locked, 0);
  endtask

  initial begin
    logic [15:0] gotPay;
    bit lockOk;
    logic [15:0] corruptPay;

    // R7: reset state while the line toggles
    rstN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      lineIn = ~lineIn;
      @(negedge clk);
    end
    check(bitValid == 1'b0 && bitData == 1'b0 && locked == 1'b0, "R7",
          "outputs in reset", {bitValid, bitData, locked}, 0);

    // R8: quiet line after reset
    doReset();
    repeat (300) @(negedge clk);
    check(rxCount == 0, "R8", "valid pulses on idle line", rxCount, 0);
    check(locked == 1'b0, "R8", "lock on idle line", locked, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) runVector(v, VECS[v]);

    // R5: corrupted bit mid-stream, then recovery
    corruptPay = 16'h6D2B;
    doReset();
    sendPreamble(1'b0, 16, 8, 8);
    sendPreamble(1'b1, 4, 8, 8);
    lineIn = 1'b1;
    repeat (16) @(negedge clk);
    sendPreamble(1'b0, 16, 8, 8);
    for (int i = 15; i >= 0; i--) sendBit(corruptPay[i], 8, 8);
    repeat (4) @(negedge clk);
    check(lockFell, "R5", "lock dropped at corrupted bit", lockFell, 1);
    gotPay = '0;
    lockOk = 1'b1;
    if (rxCount >= 16 && rxCount <= 64) begin
      for (int k = 0; k < 16; k++) begin
        gotPay[15 - k] = rxBits[rxCount - 16 + k];
        if (rxLock[rxCount - 16 + k] !== 1'b1) lockOk = 1'b0;
      end
    end else lockOk = 1'b0;
    check(gotPay == corruptPay, "R1", "payload after realignment", gotPay, corruptPay);
    check(lockOk, "R6", "relocked before payload", lockOk, 1);

    // R7: reset after activity clears outputs
    @(negedge clk);
    rstN = 1'b0;
    lineIn = 1'b1;
    repeat (3) @(negedge clk);
    check(bitValid == 1'b0 && bitData == 1'b0 && locked == 1'b0, "R7",
          "outputs after mid-run reset", {bitValid, bitData, locked}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL all watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule